// File: doc/BRIEF.md
# Closed-Loop Sinusoidal PWM Bridge Modulator

This block drives the four switches of a full H-bridge so that the bridge output follows a sampled sinusoidal setpoint. Once per carrier period it subtracts the filtered output measurement from the setpoint, scales the difference by a proportional gain held in unsigned fixed point, and stores the result as a signed control value. A free-running sawtooth counter, shared by both legs, is compared against the control value to command leg A and against the negated control value to command leg B.

Each leg passes its command through a dead-time stage. The stage holds both switches of that leg off until the command has stayed steady for a programmable number of clocks. The block also reports two conduction windows: the positive window is open when the high switch of leg A and the low switch of leg B are both on, and the negative window is open when the high switch of leg B and the low switch of leg A are both on. A positive control value therefore produces only positive windows, and a negative one produces only negative windows.

Top module: `spwm_bridge_mod`

## Requirements
- R1: At the clock edge that leaves the last count of a period, the control value becomes (setpoint − measurement) × gain / 2^FRAC, truncated toward zero. Setpoint and measurement are two's-complement DW-bit values, and gain is an unsigned GW-bit value with FRAC fractional bits.
- R2: The carrier count starts at 0 in the first cycle after reset and rises by one each clock, wrapping every 2^CW clocks. The signed ramp equals the count minus 2^(CW−1).
- R3: The leg A command is 1 while the control value is greater than the ramp, and the leg B command is 1 while the negated control value is greater than the ramp, both as signed compares. The high gate of a leg follows its command one clock later, and the low gate follows the inverted command.
- R4: With dead time 0, leg A high and leg B high together are on for exactly 2^CW cycles over one carrier period.
- R5: A gate turns on only after its leg command has held the same value for at least dead_in+1 consecutive cycles. Both gates of a leg are off while that condition is unmet, so with a nonzero dead time the low gate is still off in the cycle in which the high gate falls.
- R6: pos_win equals a_hi AND b_lo, neg_win equals b_hi AND a_lo, and the two windows are never open together.
- R7: The control value saturates to the range ±(2^(CW−1) − 1).
- R8: The control value changes only at the period wrap. Input changes at any other time have no effect before the next wrap.
- R9: While rst_n is low, all four gates and both windows are low.
- R10: When the control value is positive, only pos_win opens. When it is negative, only neg_win opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | DW | Signed sinusoidal setpoint sample |
| meas_in | input | DW | Signed filtered output measurement |
| gain_in | input | GW | Unsigned proportional gain, FRAC fractional bits |
| dead_in | input | DTW | Dead time in clocks |
| a_hi | output | 1 | Leg A high-side gate |
| a_lo | output | 1 | Leg A low-side gate |
| b_hi | output | 1 | Leg B high-side gate |
| b_lo | output | 1 | Leg B low-side gate |
| pos_win | output | 1 | Positive conduction window |
| neg_win | output | 1 | Negative conduction window |

## Verification
The inputs are captured at the edge that leaves count 2^CW−1, so a new control value first affects the compare at count 0. Because the gates come from one register stage, that value first shows at the gates in the cycle where the count reads 1. The gates at any cycle reflect the command of the previous cycle, further held back by the dead-time run-length rule. The bench keeps its own cycle index, ramp, control value and per-leg run lengths. It samples on the falling clock edge, and it changes the inputs only in the middle of a period so that every sample falls on a known cycle.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  localparam int unsigned NUM_LEGS = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

endpackage

// File: rtl/spwm_ramp.sv
module spwm_ramp #(
  parameter int unsigned CW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic signed [CW-1:0] ramp,
  output logic                 wrap
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // Flipping the top bit subtracts half the range: an offset-binary to signed map
  assign ramp = $signed({~cnt[CW-1], cnt[CW-2:0]});
  assign wrap = &cnt;

endmodule

// File: rtl/spwm_ctl.sv
module spwm_ctl #(
  parameter int unsigned CW   = 12,
  parameter int unsigned DW   = 12,
  parameter int unsigned GW   = 20,
  parameter int unsigned FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [DW-1:0] ref_s,
  input  logic signed [DW-1:0] meas_s,
  input  logic        [GW-1:0] gain,
  output logic signed [CW-1:0] ctl_q
);

  localparam int unsigned EW = DW + 1;
  localparam int unsigned PW = EW + GW + 1;
  localparam logic signed [PW-1:0] RND = PW'((64'd1 << FRAC) - 64'd1);
  localparam logic signed [PW-1:0] LIM = PW'((64'd1 << (CW - 1)) - 64'd1);

  function automatic logic signed [CW-1:0] scale_err(
    input logic signed [DW-1:0] r,
    input logic signed [DW-1:0] m,
    input logic        [GW-1:0] g
  );
    logic signed [EW-1:0] e;
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] q;
    e = $signed({r[DW-1], r}) - $signed({m[DW-1], m});
    p = PW'(e) * $signed(PW'({1'b0, g}));
    if (p < 0) p = p + RND;
    q = p >>> FRAC;
    if (q > LIM)       q = LIM;
    else if (q < -LIM) q = -LIM;
    return CW'(q);
  endfunction

  logic signed [CW-1:0] ctl_d;
  assign ctl_d = scale_err(ref_s, meas_s, gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= '0;
    else if (load) ctl_q <= ctl_d;
  end

endmodule

// File: rtl/spwm_leg.sv
module spwm_leg #(
  parameter int unsigned DTW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd,
  input  logic [DTW-1:0]           dead,
  output spwm_pkg::gate_pair_t     gate
);

  logic           cmd_q;
  logic [DTW-1:0] held;
  logic           settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      held  <= '0;
    end else begin
      cmd_q <= cmd;
      if (cmd != cmd_q)  held <= '0;
      else if (held != '1) held <= held + 1'b1;
    end
  end

  assign settled = (held >= dead);
  assign gate.hi = rst_n &  cmd_q & settled;
  assign gate.lo = rst_n & ~cmd_q & settled;

endmodule

// File: rtl/spwm_bridge_mod.sv
module spwm_bridge_mod #(
  parameter int unsigned CW   = 12,
  parameter int unsigned DW   = 12,
  parameter int unsigned GW   = 20,
  parameter int unsigned FRAC = 16,
  parameter int unsigned DTW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ref_in,
  input  logic [DW-1:0] meas_in,
  input  logic [GW-1:0] gain_in,
  input  logic [DTW-1:0] dead_in,
  output logic          a_hi,
  output logic          a_lo,
  output logic          b_hi,
  output logic          b_lo,
  output logic          pos_win,
  output logic          neg_win
);

  import spwm_pkg::*;

  logic signed [CW-1:0] ramp;
  logic                 ramp_wrap;
  logic signed [CW-1:0] ctl_q;
  logic signed [CW-1:0] ctl_neg;
  logic [NUM_LEGS-1:0]  leg_cmd;
  gate_pair_t           leg_gate [NUM_LEGS];

  spwm_ramp #(.CW(CW)) u_ramp (
    .clk  (clk),
    .rst_n(rst_n),
    .ramp (ramp),
    .wrap (ramp_wrap)
  );

  spwm_ctl #(.CW(CW), .DW(DW), .GW(GW), .FRAC(FRAC)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ramp_wrap),
    .ref_s ($signed(ref_in)),
    .meas_s($signed(meas_in)),
    .gain  (gain_in),
    .ctl_q (ctl_q)
  );

  assign ctl_neg    = -ctl_q;
  assign leg_cmd[0] = (ctl_q   > ramp);
  assign leg_cmd[1] = (ctl_neg > ramp);

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    spwm_leg #(.DTW(DTW)) u_leg (
      .clk  (clk),
      .rst_n(rst_n),
      .cmd  (leg_cmd[k]),
      .dead (dead_in),
      .gate (leg_gate[k])
    );
  end

  assign a_hi    = leg_gate[0].hi;
  assign a_lo    = leg_gate[0].lo;
  assign b_hi    = leg_gate[1].hi;
  assign b_lo    = leg_gate[1].lo;
  assign pos_win = a_hi & b_lo;
  assign neg_win = b_hi & a_lo;

endmodule

// File: rtl/spwm_mod_chk.sv
module spwm_mod_chk #(
  parameter int unsigned CW  = 12,
  parameter int unsigned DTW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 a_hi,
  input logic                 a_lo,
  input logic                 b_hi,
  input logic                 b_lo,
  input logic                 pos_win,
  input logic                 neg_win,
  input logic                 wrap,
  input logic signed [CW-1:0] ctl_q,
  input logic [DTW-1:0]       dead
);

  localparam int LIMV = (1 << (CW - 1)) - 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert ({a_hi, a_lo, b_hi, b_lo, pos_win, neg_win} == 6'b0)
        else $error("gates active during reset");
    end
  end

  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ctl_q));

  p_ctl_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q <= LIMV) && (ctl_q >= -LIMV));

  p_gap_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dead != '0) && $fell(a_hi)) |-> !a_lo);

  p_gap_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dead != '0) && $fell(b_hi)) |-> !b_lo);

  p_win_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_win && neg_win));

endmodule

bind spwm_bridge_mod spwm_mod_chk #(.CW(CW), .DTW(DTW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_hi   (a_hi),
  .a_lo   (a_lo),
  .b_hi   (b_hi),
  .b_lo   (b_lo),
  .pos_win(pos_win),
  .neg_win(neg_win),
  .wrap   (ramp_wrap),
  .ctl_q  (ctl_q),
  .dead   (dead_in)
);

// File: tb/sim_spwm_bridge_mod.sv
`timescale 1ns/1ps
module sim_spwm_bridge_mod;

  localparam int CW   = 6;
  localparam int DW   = 8;
  localparam int GW   = 20;
  localparam int FRAC = 16;
  localparam int DTW  = 3;
  localparam int P    = 1 << CW;
  localparam int HALF = P / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] ref_in = '0;
  logic [DW-1:0] meas_in = '0;
  logic [GW-1:0] gain_in = '0;
  logic [DTW-1:0] dead_in = '0;
  logic a_hi, a_lo, b_hi, b_lo, pos_win, neg_win;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spwm_bridge_mod #(.CW(CW), .DW(DW), .GW(GW), .FRAC(FRAC), .DTW(DTW)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .meas_in(meas_in),
    .gain_in(gain_in), .dead_in(dead_in), .a_hi(a_hi), .a_lo(a_lo),
    .b_hi(b_hi), .b_lo(b_lo), .pos_win(pos_win), .neg_win(neg_win));

  // bench model state
  int n, ctl_m, prev_a, prev_b, len_a, len_b, per;
  int acc, acc_ok, acc_on;

  function automatic int model_ctl(int r, int m, int g);
    longint prod;
    longint q;
    int lim;
    lim  = HALF - 1;
    prod = longint'(r - m) * longint'(g);
    q    = prod / 65536;  // integer division truncates toward zero
    if (q > lim)  q = lim;
    if (q < -lim) q = -lim;
    return int'(q);
  endfunction

  function automatic int gain_pick(int j);
    case (j % 6)
      0: return 3277;
      1: return 65536;
      2: return 0;
      3: return 16384;
      4: return 196608;
      default: return 1048575;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, n);
    end
  endtask

  task automatic drive_period(input int j);
    ref_in  = DW'(((j * 37) % 256) - 128);
    meas_in = DW'(((j * 91 + 13) % 256) - 128);
    gain_in = GW'(gain_pick(j));
    dead_in = (j % 5 == 0) ? '0 : DTW'(j % 4);
  endtask

  task automatic model_start();
    n = 0; ctl_m = 0; prev_a = 0; prev_b = 0; len_a = 1; len_b = 1;
    acc = 0; acc_ok = 0; acc_on = 0;
  endtask

  // evaluate state n (taken after the most recent rising edge)
  task automatic eval_state();
    int cnt, rmp, d, ea_hi, ea_lo, eb_hi, eb_lo, ca, cb;
    cnt = n % P;
    rmp = cnt - HALF;
    d   = int'(dead_in);
    ea_hi = (prev_a == 1 && len_a >= d + 1);
    ea_lo = (prev_a == 0 && len_a >= d + 1);
    eb_hi = (prev_b == 1 && len_b >= d + 1);
    eb_lo = (prev_b == 0 && len_b >= d + 1);
    // gates: control value (R1, R7, R8), ramp (R2), compare (R3), dead time (R5)
    check("R1 R2 R3 R5 R7 R8 gates{ahi,alo,bhi,blo}",
          int'({a_hi, a_lo, b_hi, b_lo}), (ea_hi << 3) | (ea_lo << 2) | (eb_hi << 1) | eb_lo);
    check("R6 windows{pos,neg}", int'({pos_win, neg_win}),
          ((ea_hi & eb_lo) << 1) | (eb_hi & ea_lo));
    // R10: sign of the control value picks the window; applies once the stored value reaches the gates
    if (cnt != 0) begin
      if (ctl_m > 0) check("R10 neg_win with positive control", int'(neg_win), 0);
      if (ctl_m < 0) check("R10 pos_win with negative control", int'(pos_win), 0);
    end
    // R4: duty sum over the window of gate states cnt=1..P (covers one period's commands)
    if (cnt == 1) begin acc = 0; acc_ok = 1; acc_on = 1; end
    if (acc_on) begin
      acc = acc + int'(a_hi) + int'(b_hi);
      if (d != 0) acc_ok = 0;
      if (cnt == 0) begin
        if (acc_ok) check("R4 duty sum per period", acc, P);
        acc_on = 0;
      end
    end
    // commands of this state feed the next state's gates
    ca = (ctl_m > rmp);
    cb = (-ctl_m > rmp);
    if (ca == prev_a) len_a++; else begin prev_a = ca; len_a = 1; end
    if (cb == prev_b) len_b++; else begin prev_b = cb; len_b = 1; end
    if (cnt == P - 1)
      ctl_m = model_ctl(int'($signed(ref_in)), int'($signed(meas_in)), int'(gain_in));
    if (cnt == HALF) begin
      per++;
      drive_period(per);
    end
    n++;
  endtask

  task automatic run_cycles(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      eval_state();
      @(negedge clk);
    end
  endtask

  task automatic reset_phase(input int cyc);
    rst_n = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      #1;
      check("R9 outputs during reset", int'({a_hi, a_lo, b_hi, b_lo, pos_win, neg_win}), 0);
    end
    rst_n = 1'b1;
    #1;
    model_start();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    per = 0;
    drive_period(0);
    reset_phase(4);
    run_cycles(300 * P);
    // reset again mid-run, then resume with fresh model state
    @(negedge clk);
    reset_phase(3);
    run_cycles(12 * P);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule